// File: doc/BRIEF.md
# Embedded-sync 4:2:2 video byte stream generator

This block drives the 8-bit digital input of a 525-line interlaced video encoder. It runs at the byte clock, which is twice the pixel rate. Each line is a fixed sequence of byte slots:

- an end-of-active-video timing code,
- horizontal blanking filler,
- a start-of-active-video timing code,
- the active region, where two luma samples share one pair of chroma samples.

Horizontal and vertical sync are not carried on separate pins. They are coded into the timing code bytes, which also carry the field number and the vertical blanking state.

Pixel data comes from a frame-buffer read port with a fixed latency. The block issues one request for each pixel pair, early enough that the word arrives just as the pair is due. The request carries the pair column and the raster line. The returned word is then sent out as four bytes in chroma-blue, luma, chroma-red, luma order. Active bytes are clipped so that they never form the reserved code values 0x00 and 0xFF. Those values then appear only inside timing codes.

All raster sizes are parameters. The defaults give 858 pixel periods per line with 720 visible, and 525 lines with 487 visible. The two visible windows are 243 lines and 244 lines.

Top module: `bt656_stream_gen`

## Requirements
- R1: While reset is held low, `o_data` is 0x80 and `o_req` is 0.
- R2: A line lasts 2*H_TOTAL_PIX byte slots. Offsets 0..3 carry the end code FF,00,00,XY. The start code FF,00,00,XY sits in the four slots just before the active region. The active region fills the last 2*H_ACT_PIX slots.
- R3: Every code byte XY equals {1, F, V, H, V^H, F^H, F^V, F^V^H} from bit 7 down to bit 0. H is 1 in the end code and 0 in the start code.
- R4: Horizontal blanking slots between the two codes alternate 0x80 and 0x10, starting with 0x80.
- R5: With line number L counted from 0 after reset, F is 1 exactly when L >= F2_START. V is 0 exactly when V1_ACT_START <= L < V1_ACT_END or V2_ACT_START <= L < V2_ACT_END.
- R6: On lines with V=1, the active region carries alternating 0x80 and 0x10 (0x80 first), and no request is issued.
- R7: On visible lines, active pair n (n from 0) sends the returned word `i_pix_data` as bits [31:24], [23:16], [15:8], [7:0], in that order: Cb, Y, Cr, Y.
- R8: An active data byte of 0x00 is sent as 0x01, and one of 0xFF is sent as 0xFE. Outside timing codes, 0xFF is never followed by 0x00.
- R9: For each active pair of a visible line, `o_req` is high for one cycle, exactly RD_LAT+1 cycles before that pair's Cb byte is on `o_data`. At the same time `o_req_pair` holds n and `o_req_line` holds L. The word is taken from `i_pix_data` exactly RD_LAT cycles after the request.
- R10: After V_TOTAL lines the line number returns to 0, and the next frame repeats the same sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| i_clk | input | 1 | Byte clock (twice the pixel rate) |
| i_rst_n | input | 1 | Synchronous active-low reset |
| i_pix_data | input | 32 | Returned pair word {Cb, Y0, Cr, Y1}, valid RD_LAT cycles after a request |
| o_data | output | 8 | Multiplexed video byte stream |
| o_req | output | 1 | One-cycle pixel pair request |
| o_req_pair | output | PAIR_W | Pair column of the request |
| o_req_line | output | LINE_W | Raster line of the request |

## Verification
The bench uses a small raster of 32 byte slots and 10 lines, and compares every output byte over two full frames and part of a third against an arithmetic model.

The read-port model returns a pattern word keyed by line and pair. Its chroma sweeps 0x00, 0x55, 0xAA, 0xFF, so the clipping boundaries appear at both ends. This pattern shows whether:

- the byte order within a pair is right,
- the capture cycle is right,
- the wrong pair or line is being fetched.

Outside the capture cycle the port drives a fixed decoy word, so a design that samples early or late shows the decoy instead. Lines in each of the four vertical zones exercise every F/V code combination. The third frame shows whether the raster wraps correctly.

// File: rtl/vid_pkg.sv
// Shared definitions for the embedded-sync video stream generator.
// Assumes the timing code layout FF,00,00,XY with protection bits in XY.
package vid_pkg;

    typedef enum logic [1:0] {
        SEG_END_CODE,
        SEG_HBLANK,
        SEG_START_CODE,
        SEG_ACTIVE
    } seg_e;

    localparam logic [7:0] BLANK_CHROMA = 8'h80;
    localparam logic [7:0] BLANK_LUMA   = 8'h10;

    // Build the fourth timing-code byte with its protection bits
    function automatic logic [7:0] code_word(input logic f, input logic v, input logic h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

    // Keep data bytes clear of the reserved code values
    function automatic logic [7:0] clip_data(input logic [7:0] b);
        if (b == 8'hFF) return 8'hFE;
        if (b == 8'h00) return 8'h01;
        return b;
    endfunction

endpackage

// File: rtl/vid_raster.sv
// Raster position counters: byte slot within the line and line within the frame.
// Also decodes the field and vertical-blanking flags for the current line.
// Assumes every window boundary lies within 0..V_TOTAL.
module vid_raster #(
    parameter int LINE_BYTES   = 1716,
    parameter int V_TOTAL      = 525,
    parameter int V1_ACT_START = 20,
    parameter int V1_ACT_END   = 263,
    parameter int F2_START     = 263,
    parameter int V2_ACT_START = 281,
    parameter int V2_ACT_END   = 525,
    parameter int HW           = 11,
    parameter int LW           = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [HW-1:0] hcnt,
    output logic [LW-1:0] line,
    output logic          field,
    output logic          vblank
);

    localparam logic [HW-1:0] H_LAST = HW'(LINE_BYTES - 1);
    localparam logic [LW-1:0] V_LAST = LW'(V_TOTAL - 1);
    localparam logic [LW:0]   W1_LO  = (LW+1)'(V1_ACT_START);
    localparam logic [LW:0]   W1_HI  = (LW+1)'(V1_ACT_END);
    localparam logic [LW:0]   W2_LO  = (LW+1)'(V2_ACT_START);
    localparam logic [LW:0]   W2_HI  = (LW+1)'(V2_ACT_END);
    localparam logic [LW:0]   F2_LO  = (LW+1)'(F2_START);

    logic [LW:0] line_x;
    logic        in_win1;
    logic        in_win2;

    // Advance the slot counter and roll the line counter at the end of each line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hcnt <= '0;
            line <= '0;
        end else if (hcnt == H_LAST) begin
            hcnt <= '0;
            line <= (line == V_LAST) ? '0 : line + 1'b1;
        end else begin
            hcnt <= hcnt + 1'b1;
        end
    end

    // Decode field and vertical blanking from the line number
    always_comb begin
        line_x  = {1'b0, line};
        in_win1 = (line_x >= W1_LO) && (line_x < W1_HI);
        in_win2 = (line_x >= W2_LO) && (line_x < W2_HI);
        vblank  = !(in_win1 || in_win2);
        field   = (line_x >= F2_LO);
    end

endmodule

// File: rtl/vid_fetch.sv
// Pixel-pair request generator. It looks RD_LAT+1 slots ahead of the slot
// being emitted and raises a one-cycle request when that slot is the Cb byte
// of a pair on a visible line. Assumes RD_LAT+1 < ACT_START.
module vid_fetch #(
    parameter int LINE_BYTES = 1716,
    parameter int ACT_START  = 276,
    parameter int RD_LAT     = 4,
    parameter int HW         = 11,
    parameter int LW         = 10,
    parameter int PAIR_W     = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HW-1:0]     hcnt,
    input  logic [LW-1:0]     line,
    input  logic              vblank,
    output logic              req,
    output logic [PAIR_W-1:0] req_pair,
    output logic [LW-1:0]     req_line
);

    localparam logic [HW:0] LEAD_X  = (HW+1)'(RD_LAT + 1);
    localparam logic [HW:0] ACT_X   = (HW+1)'(ACT_START);
    localparam logic [HW:0] LINE_X  = (HW+1)'(LINE_BYTES);
    localparam logic [HW:0] PHASE_M = (HW+1)'(3);

    logic [HW:0]       ahead;
    logic [HW:0]       rel;
    logic              hit;
    logic [PAIR_W-1:0] pair_cnt;
    logic [PAIR_W-1:0] pair_base;

    // Find whether the look-ahead slot opens an active pair
    always_comb begin
        ahead     = {1'b0, hcnt} + LEAD_X;
        rel       = ahead - ACT_X;
        hit       = !vblank && (ahead >= ACT_X) && (ahead < LINE_X) && ((rel & PHASE_M) == '0);
        pair_base = (hcnt == '0) ? '0 : pair_cnt;
    end

    // Register the request and count pairs within the line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req      <= 1'b0;
            req_pair <= '0;
            req_line <= '0;
            pair_cnt <= '0;
        end else begin
            req <= hit;
            if (hit) begin
                req_pair <= pair_base;
                req_line <= line;
                pair_cnt <= pair_base + 1'b1;
            end else begin
                pair_cnt <= pair_base;
            end
        end
    end

endmodule

// File: rtl/vid_mux.sv
// Byte selector and output register. It picks a timing code, blanking filler
// or clipped pair data for the current slot and registers it onto the stream.
// Assumes the returned pair word is valid in the slot of the pair's Cb byte.
module vid_mux #(
    parameter int LINE_BYTES = 1716,
    parameter int ACT_START  = 276,
    parameter int HW         = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [HW-1:0] hcnt,
    input  logic          field,
    input  logic          vblank,
    input  logic [31:0]   pix_word,
    output logic [7:0]    data
);
    import vid_pkg::*;

    localparam int            SAV_AT  = ACT_START - 4;
    localparam logic [HW-1:0] CODE_N  = HW'(4);
    localparam logic [HW-1:0] SAV_X   = HW'(SAV_AT);
    localparam logic [HW-1:0] ACT_X   = HW'(ACT_START);
    localparam logic [HW-1:0] PHASE_M = HW'(3);

    seg_e          seg;
    logic [HW-1:0] code_idx;
    logic [HW-1:0] phase;
    logic [31:0]   held;
    logic [7:0]    raw;
    logic [7:0]    next_byte;
    logic          take;

    // Classify the current slot and its position inside code or pair
    always_comb begin
        if (hcnt < CODE_N) begin
            seg      = SEG_END_CODE;
            code_idx = hcnt & PHASE_M;
        end else if (hcnt < SAV_X) begin
            seg      = SEG_HBLANK;
            code_idx = '0;
        end else if (hcnt < ACT_X) begin
            seg      = SEG_START_CODE;
            code_idx = (hcnt - SAV_X) & PHASE_M;
        end else begin
            seg      = SEG_ACTIVE;
            code_idx = '0;
        end
        phase = (hcnt - ACT_X) & PHASE_M;
        take  = (seg == SEG_ACTIVE) && !vblank && (phase == '0);
    end

    // Pick the active byte: Cb live from the port, the rest from the held word
    always_comb begin
        unique case (phase)
            HW'(0):  raw = pix_word[31:24];
            HW'(1):  raw = held[23:16];
            HW'(2):  raw = held[15:8];
            default: raw = held[7:0];
        endcase
    end

    // Select the byte for this slot
    always_comb begin
        next_byte = hcnt[0] ? BLANK_LUMA : BLANK_CHROMA;
        unique case (seg)
            SEG_END_CODE, SEG_START_CODE: begin
                if (code_idx == '0)
                    next_byte = 8'hFF;
                else if (code_idx == PHASE_M)
                    next_byte = code_word(field, vblank, seg == SEG_END_CODE);
                else
                    next_byte = 8'h00;
            end
            SEG_ACTIVE: begin
                if (!vblank) next_byte = clip_data(raw);
            end
            default: ;
        endcase
    end

    // Hold the pair word for the three bytes after Cb
    always_ff @(posedge clk) begin
        if (!rst_n)
            held <= '0;
        else if (take)
            held <= pix_word;
    end

    // Register the stream byte
    always_ff @(posedge clk) begin
        if (!rst_n)
            data <= BLANK_CHROMA;
        else
            data <= next_byte;
    end

endmodule

// File: rtl/bt656_stream_gen.sv
// Top level of the embedded-sync 4:2:2 video byte stream generator.
// Connects the raster counters, the pair request generator and the byte mux.
// Assumes a read port with a fixed latency of RD_LAT cycles per request.
module bt656_stream_gen #(
    parameter int H_TOTAL_PIX  = 858,
    parameter int H_ACT_PIX    = 720,
    parameter int V_TOTAL      = 525,
    parameter int V1_ACT_START = 20,
    parameter int V1_ACT_END   = 263,
    parameter int F2_START     = 263,
    parameter int V2_ACT_START = 281,
    parameter int V2_ACT_END   = 525,
    parameter int RD_LAT       = 4,
    localparam int LINE_BYTES  = 2 * H_TOTAL_PIX,
    localparam int ACT_START   = LINE_BYTES - 2 * H_ACT_PIX,
    localparam int HW          = $clog2(LINE_BYTES),
    localparam int LINE_W      = $clog2(V_TOTAL),
    localparam int PAIR_W      = $clog2(H_ACT_PIX / 2)
) (
    input  logic              i_clk,
    input  logic              i_rst_n,
    input  logic [31:0]       i_pix_data,
    output logic [7:0]        o_data,
    output logic              o_req,
    output logic [PAIR_W-1:0] o_req_pair,
    output logic [LINE_W-1:0] o_req_line
);

    logic [HW-1:0]     hcnt;
    logic [LINE_W-1:0] line;
    logic              field;
    logic              vblank;

    vid_raster #(
        .LINE_BYTES  (LINE_BYTES),
        .V_TOTAL     (V_TOTAL),
        .V1_ACT_START(V1_ACT_START),
        .V1_ACT_END  (V1_ACT_END),
        .F2_START    (F2_START),
        .V2_ACT_START(V2_ACT_START),
        .V2_ACT_END  (V2_ACT_END),
        .HW          (HW),
        .LW          (LINE_W)
    ) u_raster (
        .clk   (i_clk),
        .rst_n (i_rst_n),
        .hcnt  (hcnt),
        .line  (line),
        .field (field),
        .vblank(vblank)
    );

    vid_fetch #(
        .LINE_BYTES(LINE_BYTES),
        .ACT_START (ACT_START),
        .RD_LAT    (RD_LAT),
        .HW        (HW),
        .LW        (LINE_W),
        .PAIR_W    (PAIR_W)
    ) u_fetch (
        .clk     (i_clk),
        .rst_n   (i_rst_n),
        .hcnt    (hcnt),
        .line    (line),
        .vblank  (vblank),
        .req     (o_req),
        .req_pair(o_req_pair),
        .req_line(o_req_line)
    );

    vid_mux #(
        .LINE_BYTES(LINE_BYTES),
        .ACT_START (ACT_START),
        .HW        (HW)
    ) u_mux (
        .clk     (i_clk),
        .rst_n   (i_rst_n),
        .hcnt    (hcnt),
        .field   (field),
        .vblank  (vblank),
        .pix_word(i_pix_data),
        .data    (o_data)
    );

endmodule

// File: rtl/vid_checker.sv
// Protocol checks on the generator's ports, attached by bind.
module vid_checker #(
    parameter int PAIR_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic [7:0]        data,
    input logic              req,
    input logic [PAIR_W-1:0] req_pair
);

    // R8: since data bytes are clipped, FF is always a code prefix followed by 00
    p_ff_then_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(data) == 8'hFF) |-> (data == 8'h00));

    // R3: a byte following FF,00,00 carries a consistent protected code word
    p_code_protect_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(data, 3) == 8'hFF) && ($past(data, 2) == 8'h00) && ($past(data, 1) == 8'h00))
        |-> (data[7] && (data[3] == (data[5] ^ data[4])) && (data[2] == (data[6] ^ data[4]))
             && (data[1] == (data[6] ^ data[5])) && (data[0] == (data[6] ^ data[5] ^ data[4]))));

    // R9: each request lasts a single cycle
    p_req_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> !req);

    // R9: pairs after the first follow their predecessor four slots later
    p_req_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req && (req_pair != '0)) |-> ($past(req, 4) && ($past(req_pair, 4) == req_pair - 1'b1)));

endmodule

bind bt656_stream_gen vid_checker #(.PAIR_W(PAIR_W)) u_vid_checker (
    .clk     (i_clk),
    .rst_n   (i_rst_n),
    .data    (o_data),
    .req     (o_req),
    .req_pair(o_req_pair)
);

// File: tb/test_bt656_stream_gen.sv
`timescale 1ns/1ps
module test_bt656_stream_gen;

    localparam int HT  = 16;
    localparam int HA  = 8;
    localparam int VT  = 10;
    localparam int W1S = 2;
    localparam int W1E = 5;
    localparam int F2S = 5;
    localparam int W2S = 7;
    localparam int W2E = 10;
    localparam int LAT = 3;
    localparam int LB  = 2 * HT;
    localparam int ACTS = LB - 2 * HA;
    localparam int SAVS = ACTS - 4;
    localparam int LW  = $clog2(VT);
    localparam int PW  = $clog2(HA / 2);
    localparam logic [31:0] DECOY = 32'h5A3C_C35A;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [31:0]   pix = DECOY;
    logic [7:0]    o_data;
    logic          o_req;
    logic [PW-1:0] o_req_pair;
    logic [LW-1:0] o_req_line;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;

    bit  h_v [0:LAT];
    int  h_l [0:LAT];
    int  h_p [0:LAT];

    always #10 clk = ~clk;

    bt656_stream_gen #(
        .H_TOTAL_PIX(HT), .H_ACT_PIX(HA), .V_TOTAL(VT),
        .V1_ACT_START(W1S), .V1_ACT_END(W1E), .F2_START(F2S),
        .V2_ACT_START(W2S), .V2_ACT_END(W2E), .RD_LAT(LAT)
    ) i_bt656_stream_gen (
        .i_clk(clk), .i_rst_n(rst_n), .i_pix_data(pix),
        .o_data(o_data), .o_req(o_req), .o_req_pair(o_req_pair), .o_req_line(o_req_line)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // R5: vertical blanking per line
    function automatic bit vb(input int l);
        return !((l >= W1S && l < W1E) || (l >= W2S && l < W2E));
    endfunction

    function automatic logic [31:0] pat(input int l, input int p);
        logic [7:0] cb;
        cb = 8'(p * 85);
        return {cb, 8'(l * 51 + p * 64), 8'(255 - p * 85), 8'(l * 16 + p + 1)};
    endfunction

    // R8: clipping model
    function automatic logic [7:0] clipb(input logic [7:0] b);
        return (b == 8'hFF) ? 8'hFE : (b == 8'h00) ? 8'h01 : b;
    endfunction

    function automatic logic [7:0] exp_byte(input int s, output string tag);
        int l, k, rel;
        bit f, v;
        logic [31:0] w;
        l = (s / LB) % VT;
        k = s % LB;
        f = (l >= F2S);
        v = vb(l);
        if (k < 4 || (k >= SAVS && k < ACTS)) begin
            rel = (k < 4) ? k : k - SAVS;
            tag = (s >= LB * VT && l == 0) ? "R10 code" : (rel == 3) ? "R3/R5 code word" : "R2 code prefix";
            if (rel == 0) return 8'hFF;
            if (rel < 3) return 8'h00;
            return {1'b1, f, v, (k < 4), v ^ (k < 4), f ^ (k < 4), f ^ v, f ^ v ^ (k < 4)};
        end
        if (k < SAVS) begin
            tag = "R4 hblank";
            return k[0] ? 8'h10 : 8'h80;
        end
        if (v) begin
            tag = "R6 vblank active";
            return k[0] ? 8'h10 : 8'h80;
        end
        rel = k - ACTS;
        w = pat(l, rel / 4);
        case (rel % 4)
            0: tag = "R7/R8 Cb";
            1: tag = "R7/R8 Y0";
            2: tag = "R7/R8 Cr";
            default: tag = "R7/R8 Y1";
        endcase
        return clipb(w[31 - 8 * (rel % 4) -: 8]);
    endfunction

    initial begin
        for (int i = 0; i <= LAT; i++) begin
            h_v[i] = 1'b0; h_l[i] = 0; h_p[i] = 0;
        end
        repeat (3) @(negedge clk);
        chk("R1 reset data", 32'(o_data), 32'h80);
        chk("R1 reset req", 32'(o_req), 32'h0);
        rst_n = 1'b1;
        for (int s = 0; s < 2 * LB * VT + 3 * LB; s++) begin
            string tag;
            logic [7:0] eb;
            int t, lt, kt;
            bit er;
            @(negedge clk);
            eb = exp_byte(s, tag);
            chk(tag, 32'(o_data), 32'(eb));
            t  = s + LAT + 1;
            lt = (t / LB) % VT;
            kt = t % LB;
            er = !vb(lt) && kt >= ACTS && ((kt - ACTS) % 4 == 0);
            chk(er ? "R9 request" : "R6/R9 no request", 32'(o_req), 32'(er));
            if (er && o_req) begin
                chk("R9 request pair", 32'(o_req_pair), 32'((kt - ACTS) / 4));
                chk("R9 request line", 32'(o_req_line), 32'(lt));
            end
            // read-port model with fixed latency
            for (int i = LAT; i > 0; i--) begin
                h_v[i] = h_v[i-1]; h_l[i] = h_l[i-1]; h_p[i] = h_p[i-1];
            end
            h_v[0] = o_req; h_l[0] = int'(o_req_line); h_p[0] = int'(o_req_pair);
            pix = h_v[LAT] ? pat(h_l[LAT], h_p[LAT]) : DECOY;
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule